// File: doc/BRIEF.md
# Loss-of-Lock Clock Sustain Controller

This block sits in the transmit audio path of a locally powered node. The node's sample clock comes from a link. When that link fails and no clock can be recovered, the block does not cut the audio off at once. The local clock keeps running, and the block counts a fixed window of frame-sync periods. Over that window it scales the outgoing samples from their current level down to zero in equal steps. At the end of the window it requests a reset, and the node starts again from power-up.

An optional event flag, meant to drive a general-purpose pin, marks the sustain episode. The flag rises on entry when enabled and stays high until the reset cycle has completed. Once the sustain sequence starts, it runs to the end: the lost-lock input clearing part way through does not stop it.

There are four states, and `state_o` shows them with this encoding: POWERUP = 0, NORMAL = 1, SUSTAIN = 2, RESET = 3. The transitions are:
- LOCK_ACQUIRED: POWERUP to NORMAL, when lock is present.
- LINK_LOST: NORMAL to SUSTAIN.
- WINDOW_DONE: SUSTAIN to RESET, on the last counted sync pulse.
- RESET_DONE: RESET to POWERUP, always after one cycle.

Top module: `clk_sustain_ctrl`

## Requirements
- R1: While `rst_n` is low, the outputs are `state_o` = 0 (POWERUP), `tx_out` = 0, `event_flag` = 0 and `reset_req` = 0.
- R2: In POWERUP, `tx_out` is 0 and the state stays POWERUP while `lock_lost` is 1. On the clock after a cycle with `lock_lost` = 0, the state is NORMAL (1).
- R3: In NORMAL, `tx_out` equals `tx_in` in the same cycle.
- R4: A NORMAL cycle with `lock_lost` = 1 makes the next state SUSTAIN (2), with the step count set to zero.
- R5: In SUSTAIN, `tx_out` = floor(`tx_in` × (N−1−k) / N) in two's complement. Here N = 2^RAMP_LOG2 (1024 by default), and k is the number of `sync_pulse` cycles seen since entry.
- R6: SUSTAIN lasts exactly N `sync_pulse` cycles. The cycle after the N-th such pulse is RESET (3).
- R7: RESET lasts one cycle. In that cycle `reset_req` = 1 and `tx_out` = 0, and the next state is POWERUP.
- R8: `lock_lost` returning to 0 during SUSTAIN does not end or alter the sequence.
- R9: `event_flag` takes the value of `event_en` from the NORMAL cycle that triggers LINK_LOST. It holds that value through SUSTAIN and RESET, ignoring later changes of `event_en`, and is 0 in POWERUP and NORMAL.
- R10: `sync_pulse` cycles outside SUSTAIN do not advance the step count, so the first SUSTAIN cycle always applies gain (N−1)/N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock, still running after lock loss |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_lost | input | 1 | High while the recovered clock is unreliable |
| sync_pulse | input | 1 | One-cycle pulse per frame-sync period |
| event_en | input | 1 | Enables the event flag for the next sustain entry |
| tx_in | input | DATA_W | Signed outgoing audio sample |
| tx_out | output | DATA_W | Signed sample after muting or ramp |
| state_o | output | 2 | Current state code |
| event_flag | output | 1 | Sustain event indication for a GPIO |
| reset_req | output | 1 | One-cycle request to reset the node |

## Verification
The hardest situation to reach is the end of the window, where the state moves on exactly at the N-th sync pulse and the gain has reached zero. Getting there takes a full run of 1024 frame periods without a break. The bench therefore pulses `sync_pulse` every fourth clock, so one complete sequence fits in about four thousand cycles. Within that run it clears `lock_lost` and toggles `event_en` shortly after entry, which confirms that neither input disturbs the ramp or the flag. Signed full-scale positive and negative samples are mixed into random data, so the floor rounding of the ramp is checked at both extremes.

// File: rtl/csus_pkg.sv
package csus_pkg;

    typedef enum logic [1:0] {
        ST_POWERUP = 2'd0,
        ST_NORMAL  = 2'd1,
        ST_SUSTAIN = 2'd2,
        ST_RESET   = 2'd3
    } csus_state_t;

endpackage

// File: rtl/csus_period_ctr.sv
module csus_period_ctr #(
    parameter int RAMP_LOG2 = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 advance,
    output logic [RAMP_LOG2-1:0] count,
    output logic                 last
);
    // Counts frame-sync periods spent in the sustain window.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (advance && !last) begin
            count <= count + 1'b1;
        end
    end

    // The window holds 2^RAMP_LOG2 periods, so the final one is all ones.
    assign last = &count;

endmodule

// File: rtl/csus_gain_ramp.sv
module csus_gain_ramp #(
    parameter int DATA_W    = 24,
    parameter int RAMP_LOG2 = 10
) (
    input  logic signed [DATA_W-1:0]    sample,
    input  logic        [RAMP_LOG2-1:0] count,
    output logic signed [DATA_W-1:0]    scaled
);
    localparam int GAIN_W = RAMP_LOG2 + 1;
    localparam int PROD_W = DATA_W + GAIN_W;

    logic        [RAMP_LOG2-1:0] gain_mag;
    logic signed [GAIN_W-1:0]    gain_s;
    logic signed [PROD_W-1:0]    product;

    // (N-1-count) is the bitwise complement of count when N is a power of two.
    assign gain_mag = ~count;
    assign gain_s   = signed'({1'b0, gain_mag});
    assign product  = PROD_W'(sample) * PROD_W'(gain_s);
    assign scaled   = DATA_W'(product >>> RAMP_LOG2);

endmodule

// File: rtl/csus_fsm.sv
module csus_fsm
    import csus_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        lock_lost,
    input  logic        sync_pulse,
    input  logic        event_en,
    input  logic        ramp_last,
    output csus_state_t state,
    output logic        ctr_clear,
    output logic        ctr_advance,
    output logic        event_flag
);
    csus_state_t next_state;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_POWERUP;
        end else begin
            state <= next_state;
        end
    end

    // Transitions.
    always_comb begin
        next_state = state;
        unique case (state)
            ST_POWERUP: if (!lock_lost) next_state = ST_NORMAL;      // LOCK_ACQUIRED
            ST_NORMAL:  if (lock_lost)  next_state = ST_SUSTAIN;     // LINK_LOST
            ST_SUSTAIN: if (sync_pulse && ramp_last) next_state = ST_RESET; // WINDOW_DONE
            ST_RESET:   next_state = ST_POWERUP;                     // RESET_DONE
        endcase
    end

    // Counter control.
    always_comb begin
        ctr_clear   = 1'b0;
        ctr_advance = 1'b0;
        unique case (state)
            ST_POWERUP: ;
            ST_NORMAL:  ctr_clear = 1'b1;
            ST_SUSTAIN: ctr_advance = sync_pulse;
            ST_RESET:   ;
        endcase
    end

    // Event flag: captured on entry, held until the reset cycle ends.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            event_flag <= 1'b0;
        end else if (state == ST_NORMAL && lock_lost) begin
            event_flag <= event_en;
        end else if (state == ST_RESET) begin
            event_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/clk_sustain_ctrl.sv
module clk_sustain_ctrl
    import csus_pkg::*;
#(
    parameter int DATA_W    = 24,
    parameter int RAMP_LOG2 = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     lock_lost,
    input  logic                     sync_pulse,
    input  logic                     event_en,
    input  logic signed [DATA_W-1:0] tx_in,
    output logic signed [DATA_W-1:0] tx_out,
    output logic [1:0]               state_o,
    output logic                     event_flag,
    output logic                     reset_req
);
    csus_state_t          state;
    logic                 ctr_clear;
    logic                 ctr_advance;
    logic                 ramp_last;
    logic [RAMP_LOG2-1:0] ramp_count;
    logic signed [DATA_W-1:0] ramped;

    csus_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .lock_lost   (lock_lost),
        .sync_pulse  (sync_pulse),
        .event_en    (event_en),
        .ramp_last   (ramp_last),
        .state       (state),
        .ctr_clear   (ctr_clear),
        .ctr_advance (ctr_advance),
        .event_flag  (event_flag)
    );

    csus_period_ctr #(.RAMP_LOG2(RAMP_LOG2)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (ctr_clear),
        .advance (ctr_advance),
        .count   (ramp_count),
        .last    (ramp_last)
    );

    csus_gain_ramp #(.DATA_W(DATA_W), .RAMP_LOG2(RAMP_LOG2)) u_ramp (
        .sample (tx_in),
        .count  (ramp_count),
        .scaled (ramped)
    );

    // Output process.
    always_comb begin
        tx_out    = '0;
        reset_req = 1'b0;
        unique case (state)
            ST_POWERUP: tx_out = '0;
            ST_NORMAL:  tx_out = tx_in;
            ST_SUSTAIN: tx_out = ramped;
            ST_RESET:   reset_req = 1'b1;
        endcase
    end

    assign state_o = state;

endmodule

// File: rtl/csus_checker.sv
module csus_checker #(
    parameter int DATA_W    = 24,
    parameter int RAMP_LOG2 = 10
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     lock_lost,
    input logic                     sync_pulse,
    input logic                     event_en,
    input logic signed [DATA_W-1:0] tx_in,
    input logic signed [DATA_W-1:0] tx_out,
    input logic [1:0]               state_o,
    input logic                     event_flag,
    input logic                     reset_req
);
    localparam logic [1:0] S_PWR = 2'd0;
    localparam logic [1:0] S_NRM = 2'd1;
    localparam logic [1:0] S_SUS = 2'd2;
    localparam logic [1:0] S_RST = 2'd3;
    localparam int CW = RAMP_LOG2 + 1;
    localparam logic [CW-1:0] LAST_SEEN = CW'((1 << RAMP_LOG2) - 1);

    logic [CW-1:0] seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen <= '0;
        end else if (state_o != S_SUS) begin
            seen <= '0;
        end else if (sync_pulse) begin
            seen <= seen + 1'b1;
        end
    end

    AST_PWR_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == S_PWR |-> (tx_out == '0 && !event_flag && !reset_req)); // R2
    AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == S_NRM |-> tx_out == tx_in); // R3
    AST_ENTER_SUS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == S_NRM && lock_lost) |=> state_o == S_SUS); // R4
    AST_WINDOW_END: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == S_SUS && sync_pulse && seen == LAST_SEEN) |=> state_o == S_RST); // R6
    AST_WINDOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == S_SUS && sync_pulse && seen != LAST_SEEN) |=> state_o == S_SUS); // R6
    AST_RST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == S_RST |=> state_o == S_PWR); // R7
    AST_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == S_SUS && !sync_pulse) |=> state_o == S_SUS); // R8
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == S_SUS |=> event_flag == $past(event_flag)); // R9
    AST_FLAG_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == S_NRM && lock_lost) |=> event_flag == $past(event_en)); // R9

    wire unused_ok = ^{event_en, tx_in[0]};

endmodule

bind clk_sustain_ctrl csus_checker #(.DATA_W(DATA_W), .RAMP_LOG2(RAMP_LOG2)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lock_lost  (lock_lost),
    .sync_pulse (sync_pulse),
    .event_en   (event_en),
    .tx_in      (tx_in),
    .tx_out     (tx_out),
    .state_o    (state_o),
    .event_flag (event_flag),
    .reset_req  (reset_req)
);

// File: tb/clk_sustain_ctrl_test.sv
module clk_sustain_ctrl_test;
    localparam int CLK_P = 10;
    localparam int DW = 24;
    localparam int RL = 10;
    localparam int NP = 1 << RL;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lock_lost = 1'b1;
    logic sync_pulse = 1'b0;
    logic event_en = 1'b0;
    logic signed [DW-1:0] tx_in = '0;
    logic signed [DW-1:0] tx_out;
    logic [1:0] state_o;
    logic event_flag;
    logic reset_req;

    int checks = 0;
    int errors = 0;
    int sus_syncs = 0;
    int sdiv = 0;
    bit cmp_on = 1'b0;

    // Behavioural reference state.
    int m_st = 0;
    int m_cnt = 0;
    int m_flag = 0;

    clk_sustain_ctrl #(.DATA_W(DW), .RAMP_LOG2(RL)) uut (
        .clk(clk), .rst_n(rst_n), .lock_lost(lock_lost), .sync_pulse(sync_pulse),
        .event_en(event_en), .tx_in(tx_in), .tx_out(tx_out), .state_o(state_o),
        .event_flag(event_flag), .reset_req(reset_req)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d time=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic longint exp_out();
        case (m_st)
            1: return longint'(tx_in);
            2: return (longint'(tx_in) * longint'(NP - 1 - m_cnt)) >>> RL;
            default: return 0;
        endcase
    endfunction

    // Stimulus generators: sync every 4th cycle, mixed data with extremes.
    always @(negedge clk) begin
        int r;
        sdiv = (sdiv + 1) % 4;
        sync_pulse = (sdiv == 0);
        r = $urandom % 8;
        if (r == 0)      tx_in = 24'sh7FFFFF;
        else if (r == 1) tx_in = -24'sh800000;
        else             tx_in = DW'($urandom);
    end

    // Reference model update.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_flag = 0;
        end else begin
            case (m_st)
                0: if (!lock_lost) m_st = 1;
                1: if (lock_lost) begin m_st = 2; m_cnt = 0; m_flag = event_en ? 1 : 0; end
                2: if (sync_pulse) begin
                       if (m_cnt == NP - 1) m_st = 3;
                       else m_cnt = m_cnt + 1;
                   end
                default: begin m_st = 0; m_flag = 0; end
            endcase
        end
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        #2;
        if (cmp_on) begin
            string st_tag, tx_tag;
            case (m_st)
                0: begin st_tag = "R2"; tx_tag = "R2"; end
                1: begin st_tag = "R4"; tx_tag = "R3"; end
                2: begin st_tag = "R6"; tx_tag = "R5"; end
                default: begin st_tag = "R7"; tx_tag = "R7"; end
            endcase
            check(st_tag, longint'(state_o), longint'(m_st));
            check(tx_tag, longint'(tx_out), exp_out());
            check("R9", longint'(event_flag), longint'(m_flag));
            check("R7", longint'(reset_req), longint'(m_st == 3));
            if (state_o == 2'd2 && sync_pulse) sus_syncs++;
        end
    end

    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL R6 watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #3;
        check("R1", longint'(state_o), 0);
        check("R1", longint'(tx_out), 0);
        check("R1", longint'(event_flag), 0);
        check("R1", longint'(reset_req), 0);
        @(negedge clk); rst_n = 1'b1; cmp_on = 1'b1;

        // R2: hold POWERUP while lock is absent, then acquire.
        repeat (6) @(negedge clk);
        lock_lost = 1'b0;
        // R10: NORMAL with many sync pulses.
        repeat (40) @(negedge clk);

        // First sustain episode with flag enabled.
        event_en = 1'b1; lock_lost = 1'b1; sus_syncs = 0;
        @(negedge clk);
        lock_lost = 1'b0; event_en = 1'b0;
        #3;
        check("R4", longint'(state_o), 2);
        check("R10", longint'(tx_out), (longint'(tx_in) * longint'(NP - 1)) >>> RL);
        repeat (20) @(negedge clk);
        #3;
        check("R8", longint'(state_o), 2);
        check("R9", longint'(event_flag), 1);
        while (state_o != 2'd3) @(negedge clk);
        #3;
        check("R7", longint'(reset_req), 1);
        check("R9", longint'(event_flag), 1);
        @(negedge clk);
        #3;
        check("R7", longint'(state_o), 0);
        check("R9", longint'(event_flag), 0);
        check("R6", longint'(sus_syncs), longint'(NP));

        // Second episode, flag disabled, lock stays lost after reset.
        repeat (10) @(negedge clk);
        event_en = 1'b0; lock_lost = 1'b1; sus_syncs = 0;
        @(negedge clk);
        #3;
        check("R9", longint'(event_flag), 0);
        while (state_o != 2'd3) @(negedge clk);
        repeat (8) @(negedge clk);
        #3;
        check("R2", longint'(state_o), 0);
        check("R6", longint'(sus_syncs), longint'(NP));
        lock_lost = 1'b0;
        repeat (10) @(negedge clk);
        #3;
        check("R2", longint'(state_o), 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule